// File: doc/BRIEF.md
# Program ROM Bank Switcher

This block sits between a CPU and a cartridge program ROM made of `NUM_BANKS` banks of 8 KB each. The CPU sees its upper 32 KB, from 0x8000 to 0xFFFF, as four 8 KB windows. Each window is served by one ROM bank. The block works out which bank serves the window under the current CPU address. It drives the full ROM address as that bank number followed by CPU address bits 12:0. The address path is purely combinational, so a read sees its bank in the same cycle.

Three write-only registers set the mapping. Two of them hold bank numbers and one holds a swap bit. The first bank register can serve either the 0x8000 window or the 0xC000 window, and the swap bit decides which. Whichever of those two windows does not receive it is pinned to bank N-2. The 0xE000 window is always bank N-1. A fourth register holds a 2-bit nametable mirroring code and drives it straight out for the video side to use.

The block has no data stream. Every pin is a plain control or address pin, with no valid/ready handshake and no back-pressure. A write takes effect on the clock edge at which the write strobe is sampled high, and it cannot be stalled.

Top module: `prg_bank_mapper`

## Requirements
- R1: While reset is asserted and after it is released, the windows at 0x8000, 0xA000, 0xC000 and 0xE000 map to banks 0, 1, N-2 and N-1, the swap bit is 0, and the mirroring output is 0.
- R2: With the swap bit at 0, a write to 0x8000 selects the bank for the 0x8000 window, and the 0xC000 window maps to bank N-2.
- R3: With the swap bit at 1, the value last written to 0x8000 serves the 0xC000 window, and the 0x8000 window maps to bank N-2.
- R4: A write to 0x9002 loads the swap bit from data bit 1. Every other data bit has no effect.
- R5: A write to 0xA000 selects the bank for the 0xA000 window.
- R6: The 0xE000 window maps to bank N-1 whatever was written.
- R7: A write to 0x9004 loads the mirroring output from data bits 1:0, encoded as 0 vertical, 1 horizontal, 2 single-screen low and 3 single-screen high.
- R8: A written bank number is truncated to its low log2(N) bits.
- R9: The ROM address output equals {bank for window of cpu_addr[14:13], cpu_addr[12:0]} in the same cycle as the address.
- R10: Only writes with `cpu_we` high to exactly 0x8000, 0x9002, 0x9004 or 0xA000 change state. Reads, and writes to any other address, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, sampled at the rising edge |
| rom_addr | output | log2(N)+13 | Program ROM address: bank number then offset |
| mirror | output | 2 | Nametable mirroring code |

## Verification
Every stored bit drives the ROM address directly, so a wrong bank or swap register shows up on `rom_addr` on the first read of an affected window after the write. No later trigger is needed. A write that lands on the wrong register, or is lost, shows up as a wrong bank in one of the windows. A swap bit that is wrongly set or cleared exchanges the 0x8000 and 0xC000 windows, so probing both windows after each mode change exposes it. A bad mirroring register appears on `mirror` one edge after the write.

// File: rtl/prgmap_pkg.sv
package prgmap_pkg;

  localparam logic [15:0] ADDR_BANK_A = 16'h8000;
  localparam logic [15:0] ADDR_MODE   = 16'h9002;
  localparam logic [15:0] ADDR_MIRROR = 16'h9004;
  localparam logic [15:0] ADDR_BANK_B = 16'hA000;

  localparam int OFFSET_W = 13;
  localparam int SWAP_BIT = 1;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

endpackage

// File: rtl/prg_cfg_regs.sv
module prg_cfg_regs
  import prgmap_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  output logic [BANK_W-1:0] bank_a,
  output logic [BANK_W-1:0] bank_b,
  output logic              swap,
  output mirror_e           mirror
);

  localparam int NREG = 2;
  localparam logic [NREG-1:0][15:0] REG_ADDR = {ADDR_BANK_B, ADDR_BANK_A};

  logic [NREG-1:0][BANK_W-1:0] bank_q;

  for (genvar i = 0; i < NREG; i++) begin : g_bank
    localparam logic [BANK_W-1:0] RST_VAL = BANK_W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[i] <= RST_VAL;
      else if (cpu_we && cpu_addr == REG_ADDR[i])
        bank_q[i] <= cpu_wdata[BANK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap   <= 1'b0;
      mirror <= MIR_VERT;
    end else if (cpu_we) begin
      if (cpu_addr == ADDR_MODE)
        swap <= cpu_wdata[SWAP_BIT];
      if (cpu_addr == ADDR_MIRROR)
        mirror <= mirror_e'(cpu_wdata[1:0]);
    end
  end

  assign bank_a = bank_q[0];
  assign bank_b = bank_q[1];

endmodule

// File: rtl/prg_window_sel.sv
module prg_window_sel #(
  parameter int NUM_BANKS = 16,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [1:0]        window,
  input  logic [BANK_W-1:0] bank_a,
  input  logic [BANK_W-1:0] bank_b,
  input  logic              swap,
  output logic [BANK_W-1:0] bank
);

  localparam logic [BANK_W-1:0] PIN_LOW  = BANK_W'(NUM_BANKS - 2);
  localparam logic [BANK_W-1:0] PIN_LAST = BANK_W'(NUM_BANKS - 1);

  always_comb begin
    unique case (window)
      2'd0:    bank = swap ? PIN_LOW : bank_a;
      2'd1:    bank = bank_b;
      2'd2:    bank = swap ? bank_a : PIN_LOW;
      default: bank = PIN_LAST;
    endcase
  end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prgmap_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROM_W  = BANK_W + OFFSET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cpu_addr,
  input  logic [7:0]       cpu_wdata,
  input  logic             cpu_we,
  output logic [ROM_W-1:0] rom_addr,
  output logic [1:0]       mirror
);

  logic [BANK_W-1:0] bank_a_q;
  logic [BANK_W-1:0] bank_b_q;
  logic              swap_q;
  mirror_e           mirror_q;
  logic [BANK_W-1:0] sel_bank;

  prg_cfg_regs #(.BANK_W(BANK_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .bank_a    (bank_a_q),
    .bank_b    (bank_b_q),
    .swap      (swap_q),
    .mirror    (mirror_q)
  );

  prg_window_sel #(.NUM_BANKS(NUM_BANKS)) u_sel (
    .window (cpu_addr[14:13]),
    .bank_a (bank_a_q),
    .bank_b (bank_b_q),
    .swap   (swap_q),
    .bank   (sel_bank)
  );

  assign rom_addr = {sel_bank, cpu_addr[OFFSET_W-1:0]};
  assign mirror   = mirror_q;

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_we,
  input logic [BANK_W+12:0] rom_addr,
  input logic [1:0]        mirror,
  input logic [BANK_W-1:0] bank_a_q,
  input logic              swap_q
);

  localparam logic [BANK_W-1:0] PIN_LOW  = BANK_W'(NUM_BANKS - 2);
  localparam logic [BANK_W-1:0] PIN_LAST = BANK_W'(NUM_BANKS - 1);

  // R6
  last_window_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[14:13] == 2'd3 |-> rom_addr[BANK_W+12:13] == PIN_LAST);

  // R2
  low_window_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_q && cpu_addr[14:13] == 2'd0) |-> rom_addr[BANK_W+12:13] == bank_a_q);

  // R3
  low_window_swapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_q && cpu_addr[14:13] == 2'd0) |-> rom_addr[BANK_W+12:13] == PIN_LOW);

  // R4
  swap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h9002) |=> swap_q == $past(cpu_wdata[1]));

  // R7
  mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'h9004) |=> mirror == $past(cpu_wdata[1:0]));

  // R10
  bank_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_addr == 16'h8000) |=> $stable(bank_a_q));

  // R9
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[12:0] == cpu_addr[12:0]);

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_we    (cpu_we),
  .rom_addr  (rom_addr),
  .mirror    (mirror),
  .bank_a_q  (bank_a_q),
  .swap_q    (swap_q)
);

// File: tb/sim_prg_bank_mapper.sv
`timescale 1ns/1ps
module sim_prg_bank_mapper;

  localparam int N      = 16;
  localparam int BW     = $clog2(N);
  localparam int RW     = BW + 13;
  localparam int PERIOD = 8;

  typedef struct {
    logic [RW-1:0] rom;
    logic [1:0]    mir;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   cpu_addr = 16'h0;
  logic [7:0]    cpu_wdata = 8'h0;
  logic          cpu_we = 1'b0;
  logic [RW-1:0] rom_addr;
  logic [1:0]    mirror;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [1:0] exp_mir = 2'd0;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  prg_bank_mapper #(.NUM_BANKS(N)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .rom_addr  (rom_addr),
    .mirror    (mirror)
  );

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_we    = 1'b1;
  endtask

  // driver: present a read address and queue the expected result
  task automatic probe(input logic [15:0] a, input int bank, input string tag,
                       input logic [7:0] d = 8'h00);
    item_t it;
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_we    = 1'b0;
    it.rom = RW'((bank << 13) | (a & 16'h1FFF));
    it.mir = exp_mir;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare just after the edge following each probe
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rom_addr !== it.rom || mirror !== it.mir) begin
        errors++;
        $display("FAIL %s: rom_addr=%h mirror=%0d expected rom_addr=%h mirror=%0d",
                 it.tag, rom_addr, mirror, it.rom, it.mir);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset map, R6, R9 offset passthrough
    probe(16'h8000, 0,   "R1 window 8000");
    probe(16'hA123, 1,   "R1 window A000");
    probe(16'hC456, N-2, "R1 window C000");
    probe(16'hFFFF, N-1, "R1 R6 window E000");
    // R2 direct mode
    wr(16'h8000, 8'h05);
    probe(16'h8010, 5,   "R2 bank in 8000");
    probe(16'hC000, N-2, "R2 C000 pinned");
    // R5
    wr(16'hA000, 8'h07);
    probe(16'hBFFF, 7,   "R5 bank in A000");
    // R8 truncation
    wr(16'h8000, 8'h3A);
    probe(16'h8001, 10,  "R8 truncated bank");
    // R4 other bits ignored
    wr(16'h9002, 8'hFD);
    probe(16'h8000, 10,  "R4 bit1 clear keeps swap 0");
    wr(16'h9002, 8'h02);
    probe(16'h8000, N-2, "R3 8000 pinned when swapped");
    probe(16'hC0F0, 10,  "R3 register serves C000");
    probe(16'hE000, N-1, "R6 E000 fixed when swapped");
    wr(16'h8000, 8'h03);
    probe(16'hC000, 3,   "R3 write lands in C000");
    // R7 mirroring encodings
    wr(16'h9004, 8'h01); exp_mir = 2'd1;
    probe(16'hA000, 7,   "R7 horizontal");
    wr(16'h9004, 8'h02); exp_mir = 2'd2;
    probe(16'hA000, 7,   "R7 single low");
    wr(16'h9004, 8'hFF); exp_mir = 2'd3;
    probe(16'hA000, 7,   "R7 single high");
    wr(16'h9004, 8'hFC); exp_mir = 2'd0;
    probe(16'hA000, 7,   "R7 vertical");
    // R10 unmatched writes and reads
    wr(16'h8001, 8'h09);
    wr(16'h9003, 8'h00);
    wr(16'hA001, 8'h00);
    wr(16'h9005, 8'h01);
    probe(16'h8000, 7'h0, "R10 read with data", 8'h0C);
    q[q.size()-1].rom = RW'((N-2) << 13);
    probe(16'hC000, 3,   "R10 C000 unchanged");
    probe(16'hA000, 7,   "R10 A000 unchanged");
    probe(16'h8000, N-2, "R10 swap unchanged");
    // R2 register follows swap back
    wr(16'h9002, 8'h00);
    probe(16'h8000, 3,   "R2 register back in 8000");
    probe(16'hC000, N-2, "R2 C000 pinned again");
    // R1 reset restores map
    @(negedge clk);
    rst_n = 1'b0;
    exp_mir = 2'd0;
    @(negedge clk);
    rst_n = 1'b1;
    probe(16'h8000, 0,   "R1 after reset 8000");
    probe(16'hA000, 1,   "R1 after reset A000");
    probe(16'hC000, N-2, "R1 after reset C000");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule